// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between a processor's load/store request port and a single memory port. Stores are written into a small first-in first-out queue and accepted at once. They are then written to memory in the background, one per cycle, whenever the memory port has nothing more urgent to do. Loads take precedence at the memory port. Each load address is compared with every queued store. A load that matches is answered straight from the queue with the youngest matching data. A load that does not match goes to memory ahead of any older queued stores, since those stores are all to other addresses.

One load may wait on memory at a time. Stores are still accepted while that load is waiting, and draining continues. When the queue is full, stores stall through the request ready signal, but loads are still taken. The memory is assumed to handle its requests in the order it accepts them, and to return one read response for each read.

Top module: `store_buffer_fwd`

## Requirements
- R1: A store is accepted (req_ready_o high) whenever fewer than DEPTH stores are queued. In the cycle after a store is accepted, drain_empty_o is low.
- R2: Queued stores go to memory as writes (mem_req_write_o = 1) in the order they were accepted, with their own address and data. One store leaves per cycle while mem_req_ready_i is high and no load needs the port.
- R3: With DEPTH stores queued, req_ready_o is low for a store request and that store is dropped. A load request is still accepted in this state.
- R4: In a cycle where a load that misses the queue and a queued store both want the memory port, the port carries the load as a read (mem_req_write_o = 0) with the load address.
- R5: A load whose address equals a queued store's address is answered with rsp_valid_o high in the cycle after it is accepted, and it issues no memory read.
- R6: When several queued stores match a load address, the data returned is that of the most recently accepted one.
- R7: A load that matches no queued store is sent to memory as a read in the cycle it is accepted. Its response appears on rsp_valid_o/rsp_data_o one cycle after mem_rsp_valid_i. Once a store has drained, a load to the same address reads the stored value from memory.
- R8: drain_empty_o is high exactly when no stores are queued. No memory write is issued while it is high.
- R9: After reset, drain_empty_o is high, rsp_valid_o and mem_req_valid_o are low, and req_ready_o is high.
- R10: While a load is waiting on memory, req_ready_o is low for a new load request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle |
| req_is_store_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Request address |
| req_data_i | input | DATA_W | Store data |
| rsp_valid_o | output | 1 | Load data valid |
| rsp_data_o | output | DATA_W | Load data |
| mem_req_valid_o | output | 1 | Memory request present |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_write_o | output | 1 | 1 = write, 0 = read |
| mem_req_addr_o | output | ADDR_W | Memory address |
| mem_req_data_o | output | DATA_W | Memory write data |
| mem_rsp_valid_i | input | 1 | Memory read data valid |
| mem_rsp_data_i | input | DATA_W | Memory read data |
| drain_empty_o | output | 1 | No stores queued |

## Verification
The queue is filled while memory is held off. Two of the stores go to the same address, so a hit load must return the younger value and issue no memory read. A miss load is then offered in the same cycle that memory becomes ready, which shows whether the read goes out ahead of the waiting writes. After that the write order and back-to-back drain timing are checked. A load to a drained address then shows whether data reaches memory intact. Extra store and load requests are offered while the queue is full and while a read is pending, which separates the store stall from the load stall.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic {
    MEM_RD = 1'b0,
    MEM_WR = 1'b1
  } mem_op_e;
endpackage

// File: rtl/sb_store_fifo.sv
module sb_store_fifo #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] addr_o [DEPTH],
  output logic [DATA_W-1:0] data_o [DEPTH],
  output logic [PTR_W-1:0]  head_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  count_q;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[tail_q] <= push_addr_i;
      data_q[tail_q] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) tail_q <= ptr_inc(tail_q);
      if (pop_i)  head_q <= ptr_inc(head_q);
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + CNT_W'(1);
        2'b01:   count_q <= count_q - CNT_W'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign addr_o  = addr_q;
  assign data_o  = data_q;
  assign head_o  = head_q;
  assign count_o = count_q;
  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);
endmodule

// File: rtl/sb_fwd_match.sv
module sb_fwd_match #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [ADDR_W-1:0] addr_i [DEPTH],
  input  logic [DATA_W-1:0] data_i [DEPTH],
  input  logic [PTR_W-1:0]  head_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o
);
  // match flags indexed by age (0 = oldest)
  logic [DEPTH-1:0] match_age;

  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    logic [PTR_W-1:0] slot;
    assign slot = PTR_W'((int'(head_i) + k) % DEPTH);
    assign match_age[k] = (CNT_W'(k) < count_i) && (addr_i[slot] == ld_addr_i);
  end

  // youngest match wins: later ages override earlier ones
  always_comb begin
    hit_o  = 1'b0;
    data_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (match_age[k]) begin
        hit_o  = 1'b1;
        data_o = data_i[PTR_W'((int'(head_i) + k) % DEPTH)];
      end
    end
  end
endmodule

// File: rtl/sb_port_arb.sv
module sb_port_arb
  import sb_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              ld_want_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic              st_avail_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic              mem_ready_i,
  output logic              mem_valid_o,
  output mem_op_e           mem_op_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              ld_issue_o,
  output logic              st_pop_o
);
  always_comb begin
    mem_valid_o = ld_want_i || st_avail_i;
    if (ld_want_i) begin
      mem_op_o   = MEM_RD;
      mem_addr_o = ld_addr_i;
      mem_data_o = '0;
    end else begin
      mem_op_o   = MEM_WR;
      mem_addr_o = st_addr_i;
      mem_data_o = st_data_i;
    end
    ld_issue_o = ld_want_i && mem_ready_i;
    st_pop_o   = !ld_want_i && st_avail_i && mem_ready_i;
  end
endmodule

// File: rtl/store_buffer_fwd.sv
module store_buffer_fwd
  import sb_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_is_store_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_write_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [DATA_W-1:0] mem_req_data_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i,
  output logic              drain_empty_o
);
  logic [ADDR_W-1:0] q_addr [DEPTH];
  logic [DATA_W-1:0] q_data [DEPTH];
  logic [PTR_W-1:0]  q_head;
  logic [CNT_W-1:0]  q_count;
  logic              q_full, q_empty;

  logic              fwd_hit;
  logic [DATA_W-1:0] fwd_data;
  logic              ld_pend_q;
  logic              is_load, ld_hit_acc, ld_miss_want, ld_issue;
  logic              st_push, st_pop;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  mem_op_e           mem_op;

  assign is_load      = req_valid_i && !req_is_store_i;
  assign ld_hit_acc   = is_load && !ld_pend_q && fwd_hit;
  assign ld_miss_want = is_load && !ld_pend_q && !fwd_hit;
  assign st_push      = req_valid_i && req_is_store_i && !q_full;
  assign req_ready_o  = req_is_store_i ? !q_full
                                       : (!ld_pend_q && (fwd_hit || mem_req_ready_i));

  sb_store_fifo #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) i_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (st_push),
    .push_addr_i (req_addr_i),
    .push_data_i (req_data_i),
    .pop_i       (st_pop),
    .addr_o      (q_addr),
    .data_o      (q_data),
    .head_o      (q_head),
    .count_o     (q_count),
    .full_o      (q_full),
    .empty_o     (q_empty)
  );

  sb_fwd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) i_match (
    .ld_addr_i (req_addr_i),
    .addr_i    (q_addr),
    .data_i    (q_data),
    .head_i    (q_head),
    .count_i   (q_count),
    .hit_o     (fwd_hit),
    .data_o    (fwd_data)
  );

  sb_port_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_arb (
    .ld_want_i   (ld_miss_want),
    .ld_addr_i   (req_addr_i),
    .st_avail_i  (!q_empty),
    .st_addr_i   (q_addr[q_head]),
    .st_data_i   (q_data[q_head]),
    .mem_ready_i (mem_req_ready_i),
    .mem_valid_o (mem_req_valid_o),
    .mem_op_o    (mem_op),
    .mem_addr_o  (mem_req_addr_o),
    .mem_data_o  (mem_req_data_o),
    .ld_issue_o  (ld_issue),
    .st_pop_o    (st_pop)
  );

  assign mem_req_write_o = (mem_op == MEM_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_pend_q   <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      if (ld_issue)             ld_pend_q <= 1'b1;
      else if (mem_rsp_valid_i) ld_pend_q <= 1'b0;
      rsp_valid_q <= ld_hit_acc || (ld_pend_q && mem_rsp_valid_i);
      if (ld_hit_acc)                       rsp_data_q <= fwd_data;
      else if (ld_pend_q && mem_rsp_valid_i) rsp_data_q <= mem_rsp_data_i;
    end
  end

  assign rsp_valid_o   = rsp_valid_q;
  assign rsp_data_o    = rsp_data_q;
  assign drain_empty_o = q_empty;
endmodule

// File: rtl/store_buffer_fwd_chk.sv
module store_buffer_fwd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_is_store_i,
  input logic req_ready_o,
  input logic rsp_valid_o,
  input logic mem_req_valid_o,
  input logic mem_req_write_o,
  input logic drain_empty_o,
  input logic full,
  input logic hit,
  input logic ld_pend
);
  assert_store_stall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_is_store_i && full) |-> !req_ready_o);

  assert_store_fill_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_is_store_i && req_ready_o) |=> !drain_empty_o);

  assert_load_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_is_store_i && req_ready_o && !hit)
      |-> (mem_req_valid_o && !mem_req_write_o));

  assert_hit_no_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_is_store_i && req_ready_o && hit)
      |-> !(mem_req_valid_o && !mem_req_write_o));

  assert_hit_rsp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_is_store_i && req_ready_o && hit) |=> rsp_valid_o);

  assert_empty_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_empty_o |-> !(mem_req_valid_o && mem_req_write_o));

  assert_one_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_pend && req_valid_i && !req_is_store_i) |-> !req_ready_o);
endmodule

bind store_buffer_fwd store_buffer_fwd_chk i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_is_store_i  (req_is_store_i),
  .req_ready_o     (req_ready_o),
  .rsp_valid_o     (rsp_valid_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_write_o (mem_req_write_o),
  .drain_empty_o   (drain_empty_o),
  .full            (q_full),
  .hit             (fwd_hit),
  .ld_pend         (ld_pend_q)
);

// File: tb/test_store_buffer_fwd.sv
module test_store_buffer_fwd;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_is_store = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          mem_valid, mem_write, mem_ready = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic          drain_empty;

  int checks = 0, fails = 0, cyc = 0, rd_count = 0, wr_n = 0;
  logic [DW-1:0] mem [16];
  logic [AW-1:0] wr_addr [16];
  logic [DW-1:0] wr_data [16];
  int            wr_cyc  [16];

  always #5 clk = ~clk;

  store_buffer_fwd i_store_buffer_fwd (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_is_store_i(req_is_store),
    .req_addr_i(req_addr), .req_data_i(req_data),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .mem_req_valid_o(mem_valid), .mem_req_ready_i(mem_ready), .mem_req_write_o(mem_write),
    .mem_req_addr_o(mem_addr), .mem_req_data_o(mem_wdata),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data),
    .drain_empty_o(drain_empty)
  );

  // memory model: accepts one request per cycle, read data one cycle later
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_valid && mem_ready) begin
      if (mem_write) begin
        mem[mem_addr[3:0]] <= mem_wdata;
        if (wr_n < 16) begin
          wr_addr[wr_n] <= mem_addr;
          wr_data[wr_n] <= mem_wdata;
          wr_cyc[wr_n]  <= cyc;
        end
        wr_n <= wr_n + 1;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_addr[3:0]];
        rd_count      <= rd_count + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit exp_ready);
    @(negedge clk);
    req_valid = 1'b1; req_is_store = 1'b1; req_addr = a; req_data = d;
    #1 check(req_ready == exp_ready, exp_ready ? "R1 store ready" : "R3 store stall",
             DW'(req_ready), DW'(exp_ready));
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic do_load(input logic [AW-1:0] a, input logic [DW-1:0] exp_d,
                         input int exp_lat, input int exp_reads, input string req);
    int rc0, n;
    @(negedge clk);
    req_valid = 1'b1; req_is_store = 1'b0; req_addr = a;
    #1 check(req_ready == 1'b1, {req, " load ready"}, DW'(req_ready), 1);
    rc0 = rd_count;
    @(posedge clk);
    #1 req_valid = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rsp_valid && n < 10);
    check(n == exp_lat, {req, " latency"}, DW'(n), DW'(exp_lat));
    check(rsp_data == exp_d, {req, " data"}, rsp_data, exp_d);
    check(rd_count - rc0 == exp_reads, {req, " memory reads"}, DW'(rd_count - rc0),
          DW'(exp_reads));
  endtask

  task automatic wait_empty();
    int n = 0;
    while (!drain_empty && n < 50) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    #1;
    check(drain_empty == 1'b1, "R9 empty", DW'(drain_empty), 1);
    check(mem_valid == 1'b0, "R9 mem idle", DW'(mem_valid), 0);
    check(rsp_valid == 1'b0, "R9 rsp idle", DW'(rsp_valid), 0);
    check(req_ready == 1'b1, "R9 ready", DW'(req_ready), 1);
  endtask

  task automatic t_single_drain();
    mem_ready = 1'b1;
    do_store(16'h0005, 32'h5555_0001, 1'b1);
    check(drain_empty == 1'b0, "R1 queued", DW'(drain_empty), 0);
    @(negedge clk);
    wait_empty();
    check(drain_empty == 1'b1, "R8 empty after drain", DW'(drain_empty), 1);
    check(wr_n == 1 && wr_addr[0] == 16'h0005 && wr_data[0] == 32'h5555_0001,
          "R2 single write", wr_data[0], 32'h5555_0001);
  endtask

  task automatic t_fill_forward_priority();
    int base = wr_n;
    mem_ready = 1'b0;
    do_store(16'h0001, 32'hD1, 1'b1);
    do_store(16'h0002, 32'hD2, 1'b1);
    do_store(16'h0003, 32'hD3, 1'b1);
    do_store(16'h0001, 32'hD4, 1'b1);
    do_store(16'h0007, 32'hBAD, 1'b0);  // R3: full, dropped
    check(drain_empty == 1'b0, "R8 not empty", DW'(drain_empty), 0);
    // R3 load accepted while full; R5/R6 youngest hit, no read
    do_load(16'h0001, 32'hD4, 1, 0, "R6 youngest hit");
    do_load(16'h0003, 32'hD3, 1, 0, "R5 hit");
    // R4: miss load and drain compete in the same cycle
    @(negedge clk);
    req_valid = 1'b1; req_is_store = 1'b0; req_addr = 16'h0009; mem_ready = 1'b1;
    #1 check(mem_valid && !mem_write && mem_addr == 16'h0009, "R4 load wins port",
             DW'({mem_valid, mem_write}), 32'h2);
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;  // R10: second load while first pending
    #1 check(req_ready == 1'b0, "R10 load stalled", DW'(req_ready), 0);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_data == 32'hA009, "R7 miss data", rsp_data, 32'hA009);
    wait_empty();
    check(wr_n - base == 4, "R3 dropped store not written", DW'(wr_n - base), 4);
    check(wr_addr[base] == 16'h1 && wr_addr[base+1] == 16'h2 && wr_addr[base+2] == 16'h3
          && wr_addr[base+3] == 16'h1, "R2 order", DW'(wr_addr[base+3]), 1);
    check(wr_data[base+3] == 32'hD4 && wr_data[base] == 32'hD1, "R2 data",
          wr_data[base+3], 32'hD4);
    check(wr_cyc[base+3] - wr_cyc[base] == 3, "R2 one per cycle",
          DW'(wr_cyc[base+3] - wr_cyc[base]), 3);
  endtask

  task automatic t_miss_after_drain();
    do_load(16'h0001, 32'hD4, 2, 1, "R7 read drained");
    do_load(16'h000C, 32'hA00C, 2, 1, "R7 plain miss");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'hA000 + 32'(i);
    t_reset();
    #20 rst_n = 1'b1;
    t_single_drain();
    t_fill_forward_priority();
    t_miss_after_drain();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc >= 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected below 20000", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule